// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Status and Mask

This block collects the transmit-ready and receive-ready flags of a two-channel serial controller into a single status byte. Each channel owns a four-bit slot in that byte. A host-written mask byte uses the same bit layout, and the block drives one shared, active-high interrupt line whenever any status bit is set together with its mask bit.

Both channels share the single line, so the host reads the status byte to learn which channel and which direction need service. The host uses a byte-wide register port with separate read and write strobes. Reading an address returns the status byte, and writing the same address loads the mask.

A channel's transmit-ready flag stays high for as long as its holding register can take a byte. A host with nothing to send therefore clears that channel's transmit mask bit to silence the line. The status bits follow the channel flags directly. Reading them never clears them.

Top module: `dual_uart_irq_ctrl`

## Requirements
- R1: During and after synchronous reset (`rst` high), the mask is 0x00, `irq` is 0 and `rdata` is 0x00.
- R2: A read (`rd_en` high) at address 0x14 returns the status byte on `rdata` one clock later. The bits are: bit 0 = channel A TX ready (`tx_rdy[0]`), bit 1 = channel A RX ready (`rx_rdy[0]`), bit 4 = channel B TX ready (`tx_rdy[1]`), bit 5 = channel B RX ready (`rx_rdy[1]`).
- R3: Status bits 2, 3, 6 and 7 always read as 0.
- R4: Reading the status byte does not clear it. A second read with the flags unchanged returns the same value.
- R5: A write (`wr_en` high) at address 0x14 loads `wdata` into the mask, using the same bit layout as R2.
- R6: `irq` is the registered OR over all bits of (status AND mask). It reflects the flags and the mask present at the previous rising clock edge.
- R7: A write at any address other than 0x14 leaves the mask unchanged, as observed on `irq`.
- R8: A read at any address other than 0x14 returns 0x00.
- R9: Clearing a channel's TX mask bit drops `irq` one edge after the mask update, even though that channel's TX-ready flag stays high.
- R10: A read and a write at 0x14 in the same cycle are both performed. The read returns the status byte, and the write updates the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte address |
| wdata | input | 8 | Write data (mask byte) |
| rdata | output | 8 | Registered read data |
| tx_rdy | input | 2 | Per-channel transmit-ready flags, bit 0 = channel A |
| rx_rdy | input | 2 | Per-channel receive-ready flags, bit 0 = channel A |
| irq | output | 1 | Shared interrupt, active high, registered |

## Verification
The bench uses the default configuration: two channels, a four-bit stride, an eight-bit data path and the status register at 0x14. With only four flag inputs and four meaningful mask bits, every flag pattern can be swept against every mask pattern, 256 combinations in all, and the interrupt line is checked for each one. Every flag pattern is also read back twice to confirm the bit placement and that reading does not clear the status. Decoding of other addresses, transmit-mask silencing and a read and write in the same cycle are each checked on their own.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int DATA_W    = 8;
  localparam int CH_STRIDE = 4;
  localparam int TX_OFS    = 0;
  localparam int RX_OFS    = 1;

  // Bits of the status byte that carry a source for n channels
  function automatic logic [DATA_W-1:0] source_bits(input int n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < n; c++) begin
      m[c*CH_STRIDE + TX_OFS] = 1'b1;
      m[c*CH_STRIDE + RX_OFS] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_status_pack.sv
module irq_status_pack
  import uart_irq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] tx_rdy,
  input  logic [NUM_CH-1:0] rx_rdy,
  output logic [DATA_W-1:0] status
);
  localparam int USED_W = NUM_CH * CH_STRIDE;

  logic [USED_W-1:0] packed_bits;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_slot
      logic [CH_STRIDE-1:0] slot;
      always_comb begin
        slot         = '0;
        slot[TX_OFS] = tx_rdy[c];
        slot[RX_OFS] = rx_rdy[c];
      end
      assign packed_bits[c*CH_STRIDE +: CH_STRIDE] = slot;
    end
    if (USED_W < DATA_W) begin : g_pad
      assign status = {{(DATA_W-USED_W){1'b0}}, packed_bits};
    end else begin : g_full
      assign status = packed_bits[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import uart_irq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] mask_q
);
  localparam logic [DATA_W-1:0] KEEP = source_bits(NUM_CH);

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (load) mask_q <= din & KEEP;
  end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] mask,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & mask);
  end
endmodule

// File: rtl/dual_uart_irq_ctrl.sv
module dual_uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int              NUM_CH   = 2,
  parameter int              ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 6'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_CH-1:0] tx_rdy,
  input  logic [NUM_CH-1:0] rx_rdy,
  output logic              irq
);
  logic              hit;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] mask_q;

  assign hit = (addr == ISR_ADDR);

  irq_status_pack #(.NUM_CH(NUM_CH)) u_pack (
    .tx_rdy (tx_rdy),
    .rx_rdy (rx_rdy),
    .status (status)
  );

  irq_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .load   (wr_en & hit),
    .din    (wdata),
    .mask_q (mask_q)
  );

  irq_line_gen u_line (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .mask   (mask_q),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)               rdata <= '0;
    else if (rd_en && hit) rdata <= status;
    else                   rdata <= '0;
  end
endmodule

// File: rtl/dual_uart_irq_ctrl_chk.sv
module dual_uart_irq_ctrl_chk
  import uart_irq_pkg::*;
#(
  parameter int                NUM_CH   = 2,
  parameter int                ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 6'h14
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NUM_CH-1:0] tx_rdy,
  input logic [NUM_CH-1:0] rx_rdy,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq
);
  logic src_any;
  always_comb begin
    src_any = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      src_any = src_any | (tx_rdy[c] & mask_q[c*CH_STRIDE+TX_OFS])
                        | (rx_rdy[c] & mask_q[c*CH_STRIDE+RX_OFS]);
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && !irq && rdata == '0));

  assert_irq_follow_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(src_any));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~source_bits(NUM_CH)) == '0);

  assert_chA_layout_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ISR_ADDR) |=> (rdata[0] == $past(tx_rdy[0]) && rdata[1] == $past(rx_rdy[0])));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ISR_ADDR) |=> $stable(mask_q));

  assert_other_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ISR_ADDR) |=> rdata == '0);
endmodule

bind dual_uart_irq_ctrl dual_uart_irq_ctrl_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .ISR_ADDR(ISR_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .mask_q(mask_q), .irq(irq)
);

// File: tb/dual_uart_irq_ctrl_bench.sv
module dual_uart_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       rd_en, wr_en;
  logic [5:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] tx_rdy, rx_rdy;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_uart_irq_ctrl u_dual_uart_irq_ctrl (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .irq(irq)
  );

  function automatic logic [7:0] spread(input logic [3:0] f);
    return {2'b00, f[3], f[2], 2'b00, f[1], f[0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [3:0] f);
    tx_rdy = {f[2], f[0]};
    rx_rdy = {f[3], f[1]};
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic write_reg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_reg(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1; wr_en = 0; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  initial begin
    logic [7:0] r1, r2;
    rst = 1; rd_en = 0; wr_en = 0; addr = 0; wdata = 0; tx_rdy = 0; rx_rdy = 0;
    repeat (3) @(negedge clk);
    set_flags(4'hF);
    @(negedge clk);
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    check("R1 rdata in reset", rdata, 8'h00);
    rst = 0;
    @(negedge clk);
    @(negedge clk);
    check("R1 mask zero after reset", {7'b0, irq}, 8'h00);

    // R2 R3 R4: every flag pattern read twice
    for (int f = 0; f < 16; f++) begin
      set_flags(f[3:0]);
      read_reg(6'h14, r1);
      read_reg(6'h14, r2);
      check("R2 R3 status layout", r1, spread(f[3:0]));
      check("R4 read does not clear", r2, spread(f[3:0]));
    end

    // R5 R6: exhaustive flags x mask sweep
    for (int m = 0; m < 16; m++) begin
      write_reg(6'h14, spread(m[3:0]) | 8'hCC);
      for (int f = 0; f < 16; f++) begin
        set_flags(f[3:0]);
        @(negedge clk);
        check("R5 R6 irq = or(status & mask)", {7'b0, irq},
              {7'b0, |(spread(f[3:0]) & spread(m[3:0]))});
      end
    end

    // R7: write elsewhere leaves mask
    write_reg(6'h14, 8'h00);
    set_flags(4'hF);
    write_reg(6'h10, 8'hFF);
    write_reg(6'h34, 8'hFF);
    idle_cycle();
    check("R7 foreign write ignored", {7'b0, irq}, 8'h00);

    // R8: read elsewhere returns zero
    read_reg(6'h04, r1);
    check("R8 foreign read zero", r1, 8'h00);
    read_reg(6'h15, r1);
    check("R8 foreign read zero", r1, 8'h00);

    // R9: TX mask clear silences irq while flag stays high
    set_flags(4'b0001);
    write_reg(6'h14, 8'h01);
    idle_cycle();
    check("R9 tx irq raised", {7'b0, irq}, 8'h01);
    write_reg(6'h14, 8'h00);
    idle_cycle();
    check("R9 tx irq silenced", {7'b0, irq}, 8'h00);
    read_reg(6'h14, r1);
    check("R9 tx flag still set", r1, 8'h01);

    // R10: read and write at same address same cycle
    set_flags(4'b1000);
    @(negedge clk);
    rd_en = 1; wr_en = 1; addr = 6'h14; wdata = 8'h20;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    check("R10 read during write", rdata, 8'h20);
    @(negedge clk);
    check("R10 write during read", {7'b0, irq}, 8'h01);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule